// File: doc/BRIEF.md
# Base-X / SGMII In-Band Configuration Word Resolver

This block sits behind the receive side of a 1.25 Gbaud Ethernet physical coding layer and turns the 16-bit in-band configuration word sent by the link partner into a resolved link state: link-up, speed, data replication factor, duplex and the two pause directions. A single mode input picks how the word is read. In base-X mode (1000BASE-X and 2500BASE-X) the word carries duplex and pause abilities. In SGMII mode it carries link, duplex and a speed code.

Upstream logic raises a strobe with each configuration word it recovers. The block accepts a partner word only after the same value has arrived on several strobes in a row. It then runs the negotiation link timer, which is loaded with the 1.6 ms value in SGMII mode or the 10 ms value in base-X mode. Only when the timer expires, and only if the decoded word contains no conflict, are negotiation-complete and the resolved fields presented. A new partner value or a change of mode starts the whole sequence again.

Top module: `cfgword_resolver`

## Requirements
- R1: During reset and in the first cycle after it, every output is zero.
- R2: A partner word is taken only after the same value arrives on MATCH_CNT (default 3) consecutive strobes. A strobe that carries a different value restarts the count from one, with that new value.
- R3: Once a word is taken, the link timer counts down from SGMII_LOAD (default 0x186A0) in SGMII mode or from BASEX_LOAD (default 0x98968) in base-X mode. `an_done` rises exactly load+1 clock edges after the edge that takes the word.
- R4: A change of `mode_sgmii` discards the word that was taken. `an_done` is low from the second edge after the change until MATCH_CNT new strobes and a full timer run have completed.
- R5: In SGMII mode, bits 11:10 of the partner word select the speed. Code 00 gives 10 Mb/s, code 01 gives 100 Mb/s and code 10 gives 1000 Mb/s. These appear on `speed` as 0, 1 and 2, with `repl_factor` set to 100, 10 and 1.
- R6: In SGMII mode, speed code 11 raises `fault` and keeps `an_done` low. `fault` and `an_done` are never high together.
- R7: In SGMII mode, bit 12 of the partner word gives full duplex and bit 15 gives link-up.
- R8: In base-X mode, `speed` always reads 2 (1000 Mb/s) and `repl_factor` reads 1.
- R9: In base-X mode, bit 5 means full duplex and bit 6 means half duplex. If both sides set bit 5, the duplex is full. Otherwise, if both sides set bit 6, the duplex is half. If neither holds, `fault` rises and completion is withheld. A partner word of 0x00E0 against a local word of 0x01A0 resolves to full duplex, 1000 Mb/s, with pause in both directions.
- R10: Pause uses bit 7 (symmetric) and bit 8 (asymmetric) of both words. If both sides set symmetric, pause runs in both directions. If the local side sets only asymmetric and the partner sets both bits, only `pause_tx` is enabled. If the local side sets both bits and the partner sets only asymmetric, only `pause_rx` is enabled. Every other combination gives no pause.
- R11: While `an_done` is low, `link_up`, `speed`, `repl_factor`, `duplex_full`, `pause_tx` and `pause_rx` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (62.5 MHz assumed for the default loads) |
| rst | input | 1 | Synchronous active-high reset |
| mode_sgmii | input | 1 | 1 = SGMII word format, 0 = base-X format |
| local_adv | input | 16 | Local advertisement word |
| rx_word | input | 16 | Received partner configuration word |
| rx_valid | input | 1 | Strobe marking one received configuration word |
| link_up | output | 1 | Resolved link status |
| speed | output | 2 | Resolved speed: 0 = 10, 1 = 100, 2 = 1000 Mb/s |
| repl_factor | output | 7 | Data replication factor: 1, 10 or 100 |
| duplex_full | output | 1 | Resolved full duplex |
| pause_tx | output | 1 | Transmit pause enabled |
| pause_rx | output | 1 | Receive pause enabled |
| an_done | output | 1 | Negotiation complete |
| fault | output | 1 | Taken word cannot be resolved |

## Verification
The bench builds the block with SGMII_LOAD = 20 and BASEX_LOAD = 50, keeping MATCH_CNT at 3 and the timer at 20 bits. With these short loads every timer run finishes in a few dozen cycles, so the exact completion latency can be measured in both modes. They also leave room to cover the interrupted match counts, the mode switches, each SGMII speed code and the duplex and pause corner cases in one short run. The full-size loads only change the count length, and they stay within the 20-bit counter.

// File: rtl/cfgword_pkg.sv
package cfgword_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2
  } speed_e;

  typedef struct packed {
    logic       link;
    speed_e     speed;
    logic [6:0] repl;
    logic       full;
    logic       ptx;
    logic       prx;
    logic       fault;
  } resolve_t;

endpackage

// File: rtl/cfgword_filter.sv
module cfgword_filter #(
  parameter int WORD_W    = 16,
  parameter int MATCH_CNT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic              stable,
  output logic [WORD_W-1:0] held
);
  localparam int CW = $clog2(MATCH_CNT + 1);
  localparam logic [CW-1:0] CMAX = CW'(MATCH_CNT);

  logic [CW-1:0] cnt;
  logic          mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mode_q <= 1'b0;
      held   <= '0;
    end else begin
      mode_q <= mode;
      if (mode != mode_q) begin
        cnt <= '0;
      end else if (valid) begin
        if (cnt != '0 && word == held) begin
          if (cnt != CMAX) cnt <= cnt + 1'b1;
        end else begin
          held <= word;
          cnt  <= CW'(1);
        end
      end
    end
  end

  assign stable = (cnt == CMAX);
endmodule

// File: rtl/cfgword_timer.sv
module cfgword_timer #(
  parameter int TMR_W = 20,
  parameter logic [TMR_W-1:0] SGMII_LOAD = 20'h186A0,
  parameter logic [TMR_W-1:0] BASEX_LOAD = 20'h98968
) (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic run,
  output logic expired
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= BASEX_LOAD;
    else if (!run)
      cnt <= mode ? SGMII_LOAD : BASEX_LOAD;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/cfgword_decode.sv
module cfgword_decode
  import cfgword_pkg::*;
(
  input  logic        mode,
  input  logic [15:0] loc,
  input  logic [15:0] ptn,
  output resolve_t    res
);
  logic full_ok, half_ok, ls, la, ps, pa;

  always_comb begin
    res     = '0;
    full_ok = loc[5] & ptn[5];
    half_ok = loc[6] & ptn[6];
    ls = loc[7]; la = loc[8];
    ps = ptn[7]; pa = ptn[8];
    if (mode) begin
      res.link = ptn[15];
      res.full = ptn[12];
      case (ptn[11:10])
        2'b00:   begin res.speed = SPD_10;   res.repl = 7'd100; end
        2'b01:   begin res.speed = SPD_100;  res.repl = 7'd10;  end
        2'b10:   begin res.speed = SPD_1000; res.repl = 7'd1;   end
        default: res.fault = 1'b1;
      endcase
    end else begin
      res.link  = 1'b1;
      res.speed = SPD_1000;
      res.repl  = 7'd1;
      res.full  = full_ok;
      res.fault = !(full_ok || half_ok);
      res.ptx   = (ls & ps) | (!ls & la & ps & pa);
      res.prx   = (ls & ps) | (ls & la & !ps & pa);
    end
  end
endmodule

// File: rtl/cfgword_resolver.sv
module cfgword_resolver
  import cfgword_pkg::*;
#(
  parameter int TMR_W     = 20,
  parameter int MATCH_CNT = 3,
  parameter logic [TMR_W-1:0] SGMII_LOAD = 20'h186A0,
  parameter logic [TMR_W-1:0] BASEX_LOAD = 20'h98968
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode_sgmii,
  input  logic [15:0] local_adv,
  input  logic [15:0] rx_word,
  input  logic        rx_valid,
  output logic        link_up,
  output logic [1:0]  speed,
  output logic [6:0]  repl_factor,
  output logic        duplex_full,
  output logic        pause_tx,
  output logic        pause_rx,
  output logic        an_done,
  output logic        fault
);
  localparam int WORD_W = 16;

  logic              stable, expired;
  logic [WORD_W-1:0] held;
  resolve_t          res;
  speed_e            speed_q;

  cfgword_filter #(.WORD_W(WORD_W), .MATCH_CNT(MATCH_CNT)) u_filter (
    .clk(clk), .rst(rst), .mode(mode_sgmii), .valid(rx_valid),
    .word(rx_word), .stable(stable), .held(held)
  );

  cfgword_timer #(.TMR_W(TMR_W), .SGMII_LOAD(SGMII_LOAD),
                  .BASEX_LOAD(BASEX_LOAD)) u_timer (
    .clk(clk), .rst(rst), .mode(mode_sgmii), .run(stable), .expired(expired)
  );

  cfgword_decode u_decode (
    .mode(mode_sgmii), .loc(local_adv), .ptn(held), .res(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      an_done     <= 1'b0;
      fault       <= 1'b0;
      link_up     <= 1'b0;
      speed_q     <= SPD_10;
      repl_factor <= '0;
      duplex_full <= 1'b0;
      pause_tx    <= 1'b0;
      pause_rx    <= 1'b0;
    end else begin
      an_done <= expired && !res.fault;
      fault   <= stable && res.fault;
      if (expired && !res.fault) begin
        link_up     <= res.link;
        speed_q     <= res.speed;
        repl_factor <= res.repl;
        duplex_full <= res.full;
        pause_tx    <= res.ptx;
        pause_rx    <= res.prx;
      end else begin
        link_up     <= 1'b0;
        speed_q     <= SPD_10;
        repl_factor <= '0;
        duplex_full <= 1'b0;
        pause_tx    <= 1'b0;
        pause_rx    <= 1'b0;
      end
    end
  end

  assign speed = speed_q;
endmodule

// File: rtl/cfgword_resolver_checker.sv
module cfgword_resolver_checker (
  input logic       clk,
  input logic       rst,
  input logic       mode_sgmii,
  input logic       link_up,
  input logic [1:0] speed,
  input logic [6:0] repl_factor,
  input logic       duplex_full,
  input logic       pause_tx,
  input logic       pause_rx,
  input logic       an_done,
  input logic       fault
);
  assert_done_no_fault_R6: assert property (@(posedge clk) disable iff (rst)
    an_done |-> !fault);

  assert_repl_legal_R5: assert property (@(posedge clk) disable iff (rst)
    an_done |-> (repl_factor == 7'd1 || repl_factor == 7'd10 || repl_factor == 7'd100));

  assert_basex_gigabit_R8: assert property (@(posedge clk) disable iff (rst)
    (an_done && !$past(mode_sgmii)) |-> (speed == 2'd2 && repl_factor == 7'd1));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !an_done |-> (!link_up && speed == 2'd0 && repl_factor == 7'd0 &&
                  !duplex_full && !pause_tx && !pause_rx));

  assert_mode_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_sgmii != $past(mode_sgmii)) |=> ##1 !an_done);
endmodule

bind cfgword_resolver cfgword_resolver_checker u_chk (
  .clk(clk), .rst(rst), .mode_sgmii(mode_sgmii), .link_up(link_up),
  .speed(speed), .repl_factor(repl_factor), .duplex_full(duplex_full),
  .pause_tx(pause_tx), .pause_rx(pause_rx), .an_done(an_done), .fault(fault)
);

// File: tb/cfgword_resolver_bench.sv
module cfgword_resolver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SL = 20;
  localparam int XL = 50;
  localparam int MC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_sgmii = 1'b0;
  logic [15:0] local_adv = 16'h0;
  logic [15:0] rx_word = 16'h0;
  logic        rx_valid = 1'b0;
  logic        link_up, duplex_full, pause_tx, pause_rx, an_done, fault;
  logic [1:0]  speed;
  logic [6:0]  repl_factor;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgword_resolver #(.TMR_W(20), .MATCH_CNT(MC),
                     .SGMII_LOAD(20'(SL)), .BASEX_LOAD(20'(XL))) u_cfgword_resolver (
    .clk(clk), .rst(rst), .mode_sgmii(mode_sgmii), .local_adv(local_adv),
    .rx_word(rx_word), .rx_valid(rx_valid), .link_up(link_up), .speed(speed),
    .repl_factor(repl_factor), .duplex_full(duplex_full), .pause_tx(pause_tx),
    .pause_rx(pause_rx), .an_done(an_done), .fault(fault)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_tmr, m_mprev;
  int m_held;
  int e_link, e_speed, e_repl, e_full, e_ptx, e_prx, e_done, e_fault;

  always @(posedge clk) begin
    bit stab, expd, dl, dfull, dfault, dtx, drx;
    int mbps;
    if (rst) begin
      m_cnt = 0; m_tmr = XL; m_mprev = 0; m_held = 0;
      e_link = 0; e_speed = 0; e_repl = 0; e_full = 0;
      e_ptx = 0; e_prx = 0; e_done = 0; e_fault = 0;
    end else begin
      stab = (m_cnt == MC);
      expd = stab && (m_tmr == 0);
      dfault = 0; dtx = 0; drx = 0; mbps = 1000;
      if (mode_sgmii) begin
        dl = m_held[15]; dfull = m_held[12];
        case (m_held[11:10])
          2'b00: mbps = 10;
          2'b01: mbps = 100;
          2'b10: mbps = 1000;
          default: dfault = 1;
        endcase
      end else begin
        dl = 1;
        dfull = local_adv[5] && m_held[5];
        dfault = !(dfull || (local_adv[6] && m_held[6]));
        if (local_adv[7] && m_held[7]) begin dtx = 1; drx = 1; end
        else if (!local_adv[7] && local_adv[8] && m_held[7] && m_held[8]) dtx = 1;
        else if (local_adv[7] && local_adv[8] && !m_held[7] && m_held[8]) drx = 1;
      end
      e_done  = (expd && !dfault) ? 1 : 0;
      e_fault = (stab && dfault) ? 1 : 0;
      if (e_done) begin
        e_link = dl; e_full = dfull; e_ptx = dtx; e_prx = drx;
        e_speed = (mbps == 10) ? 0 : (mbps == 100) ? 1 : 2;
        e_repl = 1000 / mbps;
      end else begin
        e_link = 0; e_speed = 0; e_repl = 0; e_full = 0; e_ptx = 0; e_prx = 0;
      end
      if (!stab) m_tmr = mode_sgmii ? SL : XL;
      else if (m_tmr > 0) m_tmr--;
      if (int'(mode_sgmii) != m_mprev) m_cnt = 0;
      else if (rx_valid) begin
        if (m_cnt != 0 && int'(rx_word) == m_held) begin
          if (m_cnt < MC) m_cnt++;
        end else begin
          m_held = int'(rx_word); m_cnt = 1;
        end
      end
      m_mprev = int'(mode_sgmii);
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(an_done == e_done, "R3 an_done vs model", an_done, e_done);
      chk(link_up == e_link, "R7 link_up vs model", link_up, e_link);
      chk(speed == e_speed, "R5 speed vs model", speed, e_speed);
      chk(repl_factor == e_repl, "R5 repl vs model", repl_factor, e_repl);
      chk(duplex_full == e_full, "R9 duplex vs model", duplex_full, e_full);
      chk(pause_tx == e_ptx && pause_rx == e_prx, "R10 pause vs model",
          {pause_tx, pause_rx}, {e_ptx[0], e_prx[0]});
      chk(fault == e_fault, "R6 fault vs model", fault, e_fault);
    end
  end

  task automatic strobe(input logic [15:0] w);
    @(negedge clk); rx_word = w; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send3(input logic [15:0] w);
    for (int i = 0; i < MC; i++) strobe(w);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!an_done && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk(an_done == 0 && link_up == 0 && fault == 0 && repl_factor == 0,
        "R1 outputs during reset", an_done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({link_up, speed, repl_factor, duplex_full, pause_tx, pause_rx, an_done, fault} == 0,
        "R1 outputs after reset", an_done, 0);

    // base-X, 0x00E0 partner vs 0x01A0 local
    local_adv = 16'h01A0;
    send3(16'h00E0);
    wait_done(lat);
    chk(lat == XL + 1, "R3 base-X latency", lat, XL + 1);
    chk(speed == 2 && repl_factor == 1, "R8 base-X gigabit", speed, 2);
    chk(duplex_full == 1, "R9 0x00E0 full duplex", duplex_full, 1);
    chk(pause_tx && pause_rx, "R10 symmetric pause", {pause_tx, pause_rx}, 3);

    // broken match sequence: A A B B -> not taken
    strobe(16'h0020); strobe(16'h0020); strobe(16'h00A0); strobe(16'h00A0);
    idle(XL + 5);
    chk(an_done == 0, "R2 interrupted match not taken", an_done, 0);
    chk(link_up == 0 && speed == 0 && duplex_full == 0, "R11 idle outputs zero", speed, 0);
    strobe(16'h00A0);
    wait_done(lat);
    chk(lat == XL + 1, "R2 third match then timer", lat, XL + 1);

    // switch to SGMII: done must drop
    @(negedge clk); mode_sgmii = 1'b1;
    idle(3);
    chk(an_done == 0, "R4 mode change restarts", an_done, 0);
    send3(16'h9800);
    wait_done(lat);
    chk(lat == SL + 1, "R3 SGMII latency", lat, SL + 1);
    chk(speed == 2 && repl_factor == 1 && duplex_full && link_up, "R5 R7 code 10 gigabit full",
        speed, 2);

    send3(16'h8400);
    wait_done(lat);
    chk(speed == 1 && repl_factor == 10 && !duplex_full && link_up, "R5 R7 code 01 100M half",
        repl_factor, 10);

    send3(16'h1000);
    wait_done(lat);
    chk(speed == 0 && repl_factor == 100 && duplex_full && !link_up, "R5 R7 code 00 10M",
        repl_factor, 100);

    send3(16'h8C00);
    idle(SL + 5);
    chk(fault == 1 && an_done == 0, "R6 reserved speed code", fault, 1);

    // base-X duplex mismatch
    @(negedge clk); mode_sgmii = 1'b0; local_adv = 16'h0020;
    send3(16'h0040);
    idle(XL + 5);
    chk(fault == 1 && an_done == 0, "R9 duplex mismatch fault", fault, 1);

    local_adv = 16'h0040;
    send3(16'h0140);
    wait_done(lat);
    chk(an_done && !duplex_full && !fault, "R9 half duplex both", duplex_full, 0);

    local_adv = 16'h0120;
    send3(16'h01A0);
    wait_done(lat);
    chk(pause_tx == 1 && pause_rx == 0, "R10 tx-only pause", {pause_tx, pause_rx}, 2);

    local_adv = 16'h01A0;
    send3(16'h0120);
    wait_done(lat);
    chk(pause_tx == 0 && pause_rx == 1, "R10 rx-only pause", {pause_tx, pause_rx}, 1);

    local_adv = 16'h0120;
    send3(16'h0120);
    wait_done(lat);
    chk(pause_tx == 0 && pause_rx == 0, "R10 asym both no pause", {pause_tx, pause_rx}, 0);

    idle(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule